// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes (17 address bits, 8 data bits). The host makes single-beat requests over a valid/ready handshake. The controller turns each request into a strobe sequence whose length is counted in clock cycles. The chip select, output enable and write enable lines are all active low. Read results go back to the host with a one-cycle valid pulse. The data bus to the memory is split into an input, an output and a drive enable. The controller only drives it while the memory's own drivers are forced off.

The cycle counts come from the clock period and the memory's ns minimums, each rounded up. `READ_CYCLES` covers the address-to-data access time. `WE_CYCLES` covers the write pulse width and the setup time to the end of the write. `TURN_CYCLES` covers the memory's release of the bus after output enable rises. With the default 8 ns clock these are 2, 1 and 1.

The state machine has six states. `ST_IDLE` has the memory deselected and ready high. An accepted read moves to `ST_RD_ACCESS`, which lasts `READ_CYCLES` cycles. It then moves to `ST_RD_CAPTURE` for `TURN_CYCLES` cycles and returns to `ST_IDLE`. An accepted write moves to `ST_WR_SETUP` for one cycle with the bus driven. It then moves to `ST_WR_PULSE`, where write enable is low for `WE_CYCLES` cycles. Next is `ST_WR_RECOVER` for one cycle, with write enable high and the data still driven, and then `ST_IDLE`. Address and write data are latched when the request is accepted.

Top module: `sram_ctl`

## Requirements
- R1: During and right after reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the state machine is back in `ST_IDLE`.
- R3: For a read, starting the cycle after acceptance, `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 hold for exactly `READ_CYCLES` cycles. During that window `mem_addr` equals the accepted address.
- R4: The byte on `mem_dq_in` is sampled on the edge that ends the read access. It appears on `rd_data` with `rd_valid`=1 for exactly one cycle, `READ_CYCLES` cycles after the accepting edge. Read results return in request order.
- R5: During a write, `mem_oe_n` stays 1 throughout. `mem_we_n` is 0 for exactly `WE_CYCLES` consecutive cycles. Write enable and output enable are never low together.
- R6: `mem_dq_oe` is 1 only while `mem_oe_n` is 1. It rises one cycle before `mem_we_n` falls and falls one cycle after `mem_we_n` rises. The bus is never driven by the controller while the memory is reading out.
- R7: While `mem_ce_n` stays 0, `mem_addr` and `mem_dq_out` do not change.
- R8: Whenever `req_ready` is 1, `mem_ce_n` is 1, so the memory is in standby between requests.
- R9: After output enable rises, at least `TURN_CYCLES`+1 cycles pass before `mem_dq_oe` rises.
- R10: Changes to `req_addr`, `req_wdata` and `req_valid` while `req_ready` is 0 have no effect: no write reaches the memory for them, and the ongoing cycle keeps its latched values.
- R11: A write request never produces an `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request byte address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data coming from the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus when 1 |

## Verification
The controller is run against a behavioural memory model with these patterns:
- writes and reads at address 0, at the top address, and at scattered addresses, with data 0x00, 0xFF and mixed bytes, which tells apart address and data wiring faults;
- back-to-back write-then-read and read-then-write pairs, which separate correct turnaround from bus contention or a shortened gap;
- a request that toggles while the controller is busy, which shows whether busy-time inputs are really ignored;
- a run of writes only, which exposes any spurious read-valid pulse.

Strobe widths and read-result latency are counted cycle by cycle against values the bench derives from the ns minimums.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } ctl_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    // Round a ns-derived time up to whole clock cycles, never below one.
    function automatic int unsigned cycles_for(int unsigned t_ps, int unsigned clk_ps);
        int unsigned r;
        r = (t_ps + clk_ps - 1) / clk_ps;
        return (r == 0) ? 1 : r;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Memory-side strobe levels for each state.
    function automatic strobe_t strobes_for(ctl_state_t s);
        strobe_t v;
        v = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (s)
            ST_RD_ACCESS:  v = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
            ST_RD_CAPTURE: v = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
            ST_WR_SETUP:   v = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
            ST_WR_PULSE:   v = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
            ST_WR_RECOVER: v = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
            default:       v = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_req_latch.sv
module sram_ctl_req_latch #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int READ_CYCLES = 2,
    parameter int WE_CYCLES   = 1,
    parameter int TURN_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              accept,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_dq_oe
);

    localparam int MAX_CYC = int'(max2(max2(READ_CYCLES, WE_CYCLES), TURN_CYCLES));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(READ_CYCLES - 1);
    localparam logic [CNT_W-1:0] WE_LOAD   = CNT_W'(WE_CYCLES - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYCLES - 1);

    ctl_state_t       state, state_n;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    strobe_t          strb_n;

    assign accept = req_valid && req_ready;

    // Next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:       if (accept) state_n = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS:  if (tmr_expired) state_n = ST_RD_CAPTURE;
            ST_RD_CAPTURE: if (tmr_expired) state_n = ST_IDLE;
            ST_WR_SETUP:   state_n = ST_WR_PULSE;
            ST_WR_PULSE:   if (tmr_expired) state_n = ST_WR_RECOVER;
            ST_WR_RECOVER: state_n = ST_IDLE;
            default:       state_n = ST_IDLE;
        endcase
    end

    // Timer is reloaded on every state change with the dwell of the new state
    always_comb begin
        tmr_load = (state_n != state);
        unique case (state_n)
            ST_RD_ACCESS:  tmr_val = RD_LOAD;
            ST_RD_CAPTURE: tmr_val = TURN_LOAD;
            ST_WR_PULSE:   tmr_val = WE_LOAD;
            default:       tmr_val = '0;
        endcase
    end

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Registered outputs, decoded from the next state so strobes are glitch free
    assign strb_n = strobes_for(state_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            req_ready <= 1'b1;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            mem_ce_n  <= strb_n.ce_n;
            mem_oe_n  <= strb_n.oe_n;
            mem_we_n  <= strb_n.we_n;
            mem_dq_oe <= strb_n.drive;
            req_ready <= (state_n == ST_IDLE);
            rd_valid  <= (state == ST_RD_ACCESS) && (state_n == ST_RD_CAPTURE);
            if ((state == ST_RD_ACCESS) && (state_n == ST_RD_CAPTURE))
                rd_data <= mem_dq_in;
        end
    end

    // Handshake: acceptance drops ready on the next cycle (R2)
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // Read strobes: output enable low only with select low and write high (R3)
    p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    // Read result is a single-cycle pulse following an output-enable window (R4)
    p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    p_rvalid_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_oe_n));

    // Write and output enable never overlap (R5)
    p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // Bus ownership rules (R6)
    p_drive_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    p_we_needs_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_ce_n));
    p_drive_before_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_dq_oe));
    p_release_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> $past(mem_we_n));

    // Standby between requests (R8)
    p_idle_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = 8000,
    parameter int T_AA_PS   = 10000,
    parameter int T_PWE_PS  = 7000,
    parameter int T_AW_PS   = 8000,
    parameter int T_SD_PS   = 5000,
    parameter int T_HZOE_PS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    // Address is already stable for the setup cycle, so the pulse only needs to
    // cover what remains of the address-setup window.
    localparam int READ_CYCLES = int'(cycles_for(T_AA_PS, CLK_PS));
    localparam int AW_REST     = int'(cycles_for(T_AW_PS, CLK_PS)) - 1;
    localparam int WE_CYCLES   = int'(max2(max2(cycles_for(T_PWE_PS, CLK_PS),
                                                cycles_for(T_SD_PS, CLK_PS)),
                                           (AW_REST > 0) ? AW_REST : 1));
    localparam int TURN_CYCLES = int'(cycles_for(T_HZOE_PS, CLK_PS));

    logic accept;

    sram_ctl_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .addr_in (req_addr),
        .data_in (req_wdata),
        .addr_q  (mem_addr),
        .data_q  (mem_dq_out)
    );

    sram_ctl_fsm #(
        .DATA_W      (DATA_W),
        .READ_CYCLES (READ_CYCLES),
        .WE_CYCLES   (WE_CYCLES),
        .TURN_CYCLES (TURN_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .mem_dq_in (mem_dq_in),
        .accept    (accept),
        .req_ready (req_ready),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_oe (mem_dq_oe)
    );

    // Latched address and data stay put while the memory is selected (R7)
    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

endmodule

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;

    localparam int AW = 17;
    localparam int DW = 8;
    localparam int CLK_PS = 8000;
    // Expected dwell counts, derived here from the ns minimums
    localparam int EXP_READ = (10000 + CLK_PS - 1) / CLK_PS;
    localparam int EXP_WE   = ((8000 + CLK_PS - 1) / CLK_PS - 1 > (7000 + CLK_PS - 1) / CLK_PS)
                              ? (8000 + CLK_PS - 1) / CLK_PS - 1 : (7000 + CLK_PS - 1) / CLK_PS;
    localparam int EXP_TURN = (5000 + CLK_PS - 1) / CLK_PS;
    localparam int LIMIT    = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rd_data, mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hA5;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct { logic [DW-1:0] data; int due; } exp_t;
    exp_t sb_q[$];
    logic [DW-1:0] store  [int unsigned];
    logic [DW-1:0] shadow [int unsigned];

    sram_ctl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) if (!done && cyc > LIMIT) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
        finish_run();
    end

    // Memory model, contention and strobe-width monitors
    int oe_run = 0, we_run = 0, last_oe_low = -100;
    bit prev_drive = 0;
    always @(negedge clk) if (rst_n) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in <= store.exists(mem_addr) ? store[mem_addr] : 8'h00;
        else
            mem_dq_in <= 8'hA5;
        if (!mem_ce_n && !mem_oe_n && mem_we_n && mem_dq_oe)
            check(0, "R6 contention", 1, 0);
        if (!mem_ce_n && !mem_we_n) begin
            if (!(mem_oe_n && mem_dq_oe)) check(0, "R5/R6 write with oe low or bus undriven",
                                                {mem_oe_n, mem_dq_oe}, 2'b11);
            store[mem_addr] = mem_dq_out;
        end
        if (!mem_oe_n) begin oe_run++; last_oe_low = cyc; end
        else if (oe_run != 0) begin check(oe_run == EXP_READ, "R3 read window", oe_run, EXP_READ); oe_run = 0; end
        if (!mem_we_n) we_run++;
        else if (we_run != 0) begin check(we_run == EXP_WE, "R5 write pulse", we_run, EXP_WE); we_run = 0; end
        if (mem_dq_oe && !prev_drive)
            check(cyc - last_oe_low >= EXP_TURN + 1, "R9 turnaround gap", cyc - last_oe_low, EXP_TURN + 1);
        prev_drive = mem_dq_oe;
    end

    // Scoreboard monitor
    always @(negedge clk) if (rst_n && rd_valid) begin
        if (sb_q.size() == 0) begin
            check(0, "R11 unexpected rd_valid", 1, 0);
        end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(rd_data == e.data, "R4 read data", rd_data, e.data);
            check(cyc == e.due, "R4 read latency", cyc, e.due);
        end
    end

    // Driver
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit poke, input logic [AW-1:0] pa);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        check(mem_ce_n == 1'b1, "R8 standby before request", mem_ce_n, 1);
        @(negedge clk);
        req_valid = 0; req_addr = ~a; req_wdata = ~d;
        check(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
        check(mem_addr == a, "R3 address presented", mem_addr, a);
        if (wr) begin
            check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} == 4'b0111,
                  "R6 setup cycle strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0111);
            shadow[a] = d;
        end else begin
            check({mem_ce_n, mem_oe_n, mem_we_n} == 3'b001, "R3 read strobes",
                  {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
            sb_q.push_back('{data: shadow[a], due: cyc + EXP_READ});
        end
        if (poke) begin
            // R10: a request shown while busy must be ignored
            req_valid = 1; req_write = 1; req_addr = pa; req_wdata = 8'hC3;
            @(negedge clk);
            req_valid = 0;
            check(mem_addr == a, "R10 latched address kept", mem_addr, a);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready} == 6'b111001,
              "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready}, 6'b111001);
        rst_n = 1;
        @(negedge clk);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready} == 6'b111001,
              "R1 after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready}, 6'b111001);

        // Boundary addresses and data
        issue(1, 17'h00000, 8'h5A, 0, 0);
        issue(1, 17'h1FFFF, 8'hFF, 0, 0);
        issue(1, 17'h12345, 8'h00, 0, 0);
        issue(1, 17'h00777, 8'h3C, 0, 0);
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R11 no read result for writes", sb_q.size(), 0);
        issue(0, 17'h00000, 0, 0, 0);
        issue(0, 17'h1FFFF, 0, 0, 0);
        issue(0, 17'h12345, 0, 0, 0);

        // Turnaround: write then read same address, read then write
        issue(1, 17'h0AAAA, 8'h96, 0, 0);
        issue(0, 17'h0AAAA, 0, 0, 0);
        issue(1, 17'h15555, 8'h69, 0, 0);
        issue(0, 17'h15555, 0, 0, 0);

        // Busy-time request ignored (R10)
        issue(1, 17'h00100, 8'h11, 1, 17'h00777);
        issue(0, 17'h00100, 0, 1, 17'h00777);
        issue(0, 17'h00777, 0, 0, 0);

        // Scattered pattern
        for (int i = 0; i < 8; i++) issue(1, AW'(i * 17'h3FFF), DW'(i * 37 + 1), 0, 0);
        for (int i = 7; i >= 0; i--) issue(0, AW'(i * 17'h3FFF), 0, 0, 0);

        repeat (10) @(negedge clk);
        check(sb_q.size() == 0, "R4 all reads returned", sb_q.size(), 0);
        check(req_ready && mem_ce_n, "R8 idle standby at end", {req_ready, mem_ce_n}, 2'b11);
        check(store[17'h00777] == 8'h3C, "R10 ignored write left memory", store[17'h00777], 8'h3C);
        done = 1;
        finish_run();
    end

endmodule